// File: doc/BRIEF.md
# Enclave Build Lifecycle Sequencer

This block tracks one protected enclave through its build lifecycle. Software issues commands one at a time with a strobe, a 3-bit command code and an operand. The block decides whether each command is legal in the current lifecycle state and answers with a one-cycle accept or reject pulse. Accepted commands advance the state. A create starts a fresh build. Page adds and content extends then fold their operands into a running measurement register. An initialize finalizes that register into the enclave identity. Entry and exit then toggle an enclave-mode output, and a destroy tears everything down from any state.

The measurement update is a placeholder mixing step, not a real hash. The register is rotated left by 7 bits and XORed with a 4-bit command tag placed in its top bits and with the zero-extended operand word in its low bits. This keeps the effect of command order and content visible in the final identity. Each accepted page add also emits a one-cycle mapping-update pulse that carries the page address. Once the build is finalized the measurement is frozen, and the identity becomes readable.

Top module: `encl_lifecycle_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `life_state` is 0 (idle), `cmd_acc`, `cmd_rej`, `map_upd`, `encl_mode` and `id_valid` are 0, and `id_digest` is 0.
- R2: Code 1 (create) is accepted only in state 0. It moves to state 1 (building) and clears the measurement, so a create followed directly by an initialize yields a digest of only the initialize tag, 0x4 in the top four bits.
- R3: Code 2 (add page) is accepted only in state 1. It raises `map_upd` for exactly the response cycle with `map_addr` equal to the operand. It folds the word {permissions, operand} using tag 0x2.
- R4: Code 3 (extend) is accepted only in state 1. It folds the zero-extended operand using tag 0x3.
- R5: Every fold computes new = rotate_left(old, 7) XOR (tag << (DIGEST_W-4)) XOR zero_extend(word), so the final digest depends on the order of adds and extends.
- R6: Code 4 (initialize) is accepted only in state 1. It folds tag 0x4 with a zero word, moves to state 2 (initialized) and raises `id_valid`. From then on, adds and extends are rejected and the measurement and digest stay unchanged.
- R7: While `id_valid` is 0 (states 0 and 1), `id_digest` reads 0.
- R8: Code 5 (enter) is accepted only in state 2 and moves to state 3 (active). Code 6 (exit) is accepted only in state 3 and moves back to state 2. `encl_mode` is 1 exactly in state 3.
- R9: Code 7 (destroy) is accepted in every state. It returns to state 0, clears the measurement and digest, and drops `encl_mode` and `id_valid`.
- R10: Every strobe gets exactly one response one cycle later: either `cmd_acc` or `cmd_rej`. Code 0 and any command out of lifecycle order are rejected, and a reject leaves the state, measurement and digest unchanged.
- R11: A cycle with no strobe produces no accept, reject or mapping-update pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (0 none, 1 create, 2 add, 3 extend, 4 initialize, 5 enter, 6 exit, 7 destroy) |
| cmd_opnd | input | OPND_W | Page address for add, data chunk for extend |
| cmd_perm | input | PERM_W | Page permission bits for add |
| cmd_acc | output | 1 | One-cycle accept pulse |
| cmd_rej | output | 1 | One-cycle reject pulse |
| map_upd | output | 1 | One-cycle mapping-update pulse on an accepted add |
| map_addr | output | OPND_W | Page address of the last mapping update |
| encl_mode | output | 1 | High while the enclave is active |
| id_valid | output | 1 | High once the identity is finalized |
| id_digest | output | DIGEST_W | Finalized identity, zero when not valid |
| life_state | output | 2 | Lifecycle state (0 idle, 1 building, 2 initialized, 3 active) |

## Verification
The bench builds the block with a 32-bit digest, a 16-bit operand, 3 permission bits and a rotation of 7. At these sizes a wrap-around of the rotation and the placement of the tag are easy to follow in hex. It sweeps all eight command codes from each of the four lifecycle states, using several operand values and build histories. Each probe left in the building state is then finalized, so that the exact fold arithmetic is compared against a digest computed in the bench. Directed sequences cover two cases: an empty build, and the same two extends applied in both orders.

// File: rtl/encl_pkg.sv
package encl_pkg;

  localparam int TAG_W = 4;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_CREATE  = 3'd1,
    CMD_ADD     = 3'd2,
    CMD_EXTEND  = 3'd3,
    CMD_INIT    = 3'd4,
    CMD_ENTER   = 3'd5,
    CMD_EXIT    = 3'd6,
    CMD_DESTROY = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUILD  = 2'd1,
    ST_READY  = 2'd2,
    ST_ACTIVE = 2'd3
  } life_e;

  localparam logic [TAG_W-1:0] TAG_ADD    = 4'h2;
  localparam logic [TAG_W-1:0] TAG_EXTEND = 4'h3;
  localparam logic [TAG_W-1:0] TAG_FINAL  = 4'h4;

  // Outcome of decoding one strobe against the current state
  typedef struct packed {
    logic             legal;
    life_e            nxt;
    logic             clr;
    logic             fold;
    logic             cap;
    logic             map;
    logic [TAG_W-1:0] tag;
  } decision_t;

endpackage

// File: rtl/encl_fsm.sv
module encl_fsm
  import encl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_vld,
  input  logic [2:0] cmd_code,
  output life_e     state_q,
  output decision_t dec
);

  always_comb begin
    dec     = '0;
    dec.nxt = state_q;
    if (cmd_vld) begin
      case (cmd_code)
        CMD_CREATE: if (state_q == ST_IDLE) begin
          dec.legal = 1'b1;
          dec.nxt   = ST_BUILD;
          dec.clr   = 1'b1;
        end
        CMD_ADD: if (state_q == ST_BUILD) begin
          dec.legal = 1'b1;
          dec.fold  = 1'b1;
          dec.map   = 1'b1;
          dec.tag   = TAG_ADD;
        end
        CMD_EXTEND: if (state_q == ST_BUILD) begin
          dec.legal = 1'b1;
          dec.fold  = 1'b1;
          dec.tag   = TAG_EXTEND;
        end
        CMD_INIT: if (state_q == ST_BUILD) begin
          dec.legal = 1'b1;
          dec.fold  = 1'b1;
          dec.cap   = 1'b1;
          dec.tag   = TAG_FINAL;
          dec.nxt   = ST_READY;
        end
        CMD_ENTER: if (state_q == ST_READY) begin
          dec.legal = 1'b1;
          dec.nxt   = ST_ACTIVE;
        end
        CMD_EXIT: if (state_q == ST_ACTIVE) begin
          dec.legal = 1'b1;
          dec.nxt   = ST_READY;
        end
        CMD_DESTROY: begin
          dec.legal = 1'b1;
          dec.clr   = 1'b1;
          dec.nxt   = ST_IDLE;
        end
        default: dec.legal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            state_q <= ST_IDLE;
    else if (dec.legal) state_q <= dec.nxt;
  end

  AST_DESTROY_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code == CMD_DESTROY) |=> state_q == ST_IDLE); // R9

  AST_CREATE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code == CMD_CREATE && state_q != ST_IDLE) |=> $stable(state_q)); // R2

  AST_ENTER_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code == CMD_ENTER && state_q != ST_READY) |=> $stable(state_q)); // R8

endmodule

// File: rtl/encl_meas.sv
module encl_meas
  import encl_pkg::*;
#(
  parameter int DIGEST_W = 256,
  parameter int MIX_W    = 67,
  parameter int ROT      = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                fold,
  input  logic                cap,
  input  logic                frozen,
  input  logic [TAG_W-1:0]    tag,
  input  logic [MIX_W-1:0]    mix,
  output logic [DIGEST_W-1:0] meas_q,
  output logic [DIGEST_W-1:0] id_q
);

  localparam int PAD_W = DIGEST_W - TAG_W - MIX_W;

  logic [DIGEST_W-1:0] rot_w;
  logic [DIGEST_W-1:0] fold_w;

  // Left rotation by ROT as pure wiring
  for (genvar i = 0; i < DIGEST_W; i++) begin : g_rot
    assign rot_w[i] = meas_q[(i + DIGEST_W - ROT) % DIGEST_W];
  end

  assign fold_w = rot_w ^ {tag, {PAD_W{1'b0}}, mix};

  always_ff @(posedge clk) begin
    if (rst || clr)  meas_q <= '0;
    else if (fold)   meas_q <= fold_w;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  id_q <= '0;
    else if (cap)    id_q <= fold_w;
  end

  AST_MEAS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (frozen && !clr) |=> $stable(meas_q)); // R6

  AST_ID_STABLE_AFTER_CAP: assert property (@(posedge clk) disable iff (rst)
    (frozen && !clr) |=> $stable(id_q)); // R6

endmodule

// File: rtl/encl_resp.sv
module encl_resp
  import encl_pkg::*;
#(
  parameter int OPND_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  logic              legal,
  input  logic              map,
  input  life_e             state_q,
  input  life_e             nxt,
  input  logic [OPND_W-1:0] opnd,
  output logic              acc_q,
  output logic              rej_q,
  output logic              map_q,
  output logic [OPND_W-1:0] addr_q,
  output logic              mode_q,
  output logic              idv_q
);

  life_e after_w;
  assign after_w = legal ? nxt : state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      map_q  <= 1'b0;
      addr_q <= '0;
      mode_q <= 1'b0;
      idv_q  <= 1'b0;
    end else begin
      acc_q  <= cmd_vld && legal;
      rej_q  <= cmd_vld && !legal;
      map_q  <= map;
      if (map) addr_q <= opnd;
      mode_q <= (after_w == ST_ACTIVE);
      idv_q  <= (after_w == ST_READY) || (after_w == ST_ACTIVE);
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_q, rej_q})); // R10

  AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |=> (acc_q || rej_q)); // R10

  AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld |=> (!acc_q && !rej_q && !map_q)); // R11

  AST_MAP_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    map_q |-> acc_q); // R3

endmodule

// File: rtl/encl_lifecycle_seq.sv
module encl_lifecycle_seq
  import encl_pkg::*;
#(
  parameter int DIGEST_W = 256,
  parameter int OPND_W   = 64,
  parameter int PERM_W   = 3,
  parameter int ROT      = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_vld,
  input  logic [2:0]          cmd_code,
  input  logic [OPND_W-1:0]   cmd_opnd,
  input  logic [PERM_W-1:0]   cmd_perm,
  output logic                cmd_acc,
  output logic                cmd_rej,
  output logic                map_upd,
  output logic [OPND_W-1:0]   map_addr,
  output logic                encl_mode,
  output logic                id_valid,
  output logic [DIGEST_W-1:0] id_digest,
  output logic [1:0]          life_state
);

  localparam int MIX_W = OPND_W + PERM_W;

  life_e               state_q;
  decision_t           dec;
  logic [MIX_W-1:0]    mix_w;
  logic [DIGEST_W-1:0] meas_q;
  logic                frozen_w;

  encl_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cmd_vld  (cmd_vld),
    .cmd_code (cmd_code),
    .state_q  (state_q),
    .dec      (dec)
  );

  // Word folded into the measurement for each kind of fold
  always_comb begin
    mix_w = '0;
    if (dec.map)                    mix_w = {cmd_perm, cmd_opnd};
    else if (dec.fold && !dec.cap)  mix_w = {{PERM_W{1'b0}}, cmd_opnd};
  end

  assign frozen_w = (state_q == ST_READY) || (state_q == ST_ACTIVE);

  encl_meas #(
    .DIGEST_W (DIGEST_W),
    .MIX_W    (MIX_W),
    .ROT      (ROT)
  ) u_meas (
    .clk    (clk),
    .rst    (rst),
    .clr    (dec.clr),
    .fold   (dec.fold),
    .cap    (dec.cap),
    .frozen (frozen_w),
    .tag    (dec.tag),
    .mix    (mix_w),
    .meas_q (meas_q),
    .id_q   (id_digest)
  );

  encl_resp #(
    .OPND_W (OPND_W)
  ) u_resp (
    .clk     (clk),
    .rst     (rst),
    .cmd_vld (cmd_vld),
    .legal   (dec.legal),
    .map     (dec.map),
    .state_q (state_q),
    .nxt     (dec.nxt),
    .opnd    (cmd_opnd),
    .acc_q   (cmd_acc),
    .rej_q   (cmd_rej),
    .map_q   (map_upd),
    .addr_q  (map_addr),
    .mode_q  (encl_mode),
    .idv_q   (id_valid)
  );

  assign life_state = state_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (life_state == 2'd0 && !encl_mode && !id_valid && !cmd_acc && !cmd_rej)); // R1

  AST_MODE_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
    encl_mode == (life_state == 2'd3)); // R8

  AST_ID_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> id_digest == '0); // R7

  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    cmd_rej |-> life_state == $past(life_state)); // R10

  AST_BUILD_MEAS_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUILD) |-> id_digest == '0); // R7

endmodule

// File: tb/encl_lifecycle_seq_test.sv
`timescale 1ns/1ps
module encl_lifecycle_seq_test;

  localparam int DW = 32;
  localparam int OW = 16;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_vld = 1'b0;
  logic [2:0]    cmd_code = 3'd0;
  logic [OW-1:0] cmd_opnd = '0;
  logic [PW-1:0] cmd_perm = '0;
  logic          cmd_acc, cmd_rej, map_upd, encl_mode, id_valid;
  logic [OW-1:0] map_addr;
  logic [DW-1:0] id_digest;
  logic [1:0]    life_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]    m_state = 2'd0;
  logic [DW-1:0] m_meas  = '0;
  logic [DW-1:0] m_id    = '0;

  always #4 clk = ~clk;

  encl_lifecycle_seq #(.DIGEST_W(DW), .OPND_W(OW), .PERM_W(PW), .ROT(7)) uut (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_opnd(cmd_opnd), .cmd_perm(cmd_perm), .cmd_acc(cmd_acc),
    .cmd_rej(cmd_rej), .map_upd(map_upd), .map_addr(map_addr),
    .encl_mode(encl_mode), .id_valid(id_valid), .id_digest(id_digest),
    .life_state(life_state)
  );

  function automatic logic [DW-1:0] fold(logic [DW-1:0] m, logic [3:0] t, logic [OW+PW-1:0] w);
    return ((m << 7) | (m >> (DW - 7))) ^ {t, {(DW-4){1'b0}}} ^ {{(DW-OW-PW){1'b0}}, w};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string lab(logic [2:0] c, bit legal);
    if (!legal) return "R10";
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5, 3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic issue(logic [2:0] c, logic [OW-1:0] op, logic [PW-1:0] pm);
    bit legal;
    string r;
    case (c)
      3'd1: legal = (m_state == 2'd0);
      3'd2, 3'd3, 3'd4: legal = (m_state == 2'd1);
      3'd5: legal = (m_state == 2'd2);
      3'd6: legal = (m_state == 2'd3);
      3'd7: legal = 1'b1;
      default: legal = 1'b0;
    endcase
    cmd_vld = 1'b1; cmd_code = c; cmd_opnd = op; cmd_perm = pm;
    @(negedge clk);
    cmd_vld = 1'b0;
    if (legal) begin
      case (c)
        3'd1: begin m_state = 2'd1; m_meas = '0; end
        3'd2: m_meas = fold(m_meas, 4'h2, {pm, op});
        3'd3: m_meas = fold(m_meas, 4'h3, {{PW{1'b0}}, op});
        3'd4: begin m_meas = fold(m_meas, 4'h4, '0); m_id = m_meas; m_state = 2'd2; end
        3'd5: m_state = 2'd3;
        3'd6: m_state = 2'd2;
        default: begin m_state = 2'd0; m_meas = '0; m_id = '0; end
      endcase
    end
    r = lab(c, legal);
    chk(cmd_acc == legal, r, 64'(cmd_acc), 64'(legal));
    chk(cmd_rej == !legal, "R10", 64'(cmd_rej), 64'(!legal));
    chk(life_state == m_state, r, 64'(life_state), 64'(m_state));
    chk(map_upd == (legal && c == 3'd2), "R3", 64'(map_upd), 64'(legal && c == 3'd2));
    if (legal && c == 3'd2) chk(map_addr == op, "R3", 64'(map_addr), 64'(op));
    chk(encl_mode == (m_state == 2'd3), "R8", 64'(encl_mode), 64'(m_state == 2'd3));
    chk(id_valid == (m_state >= 2'd2), "R6", 64'(id_valid), 64'(m_state >= 2'd2));
    chk(id_digest == m_id, (m_state >= 2'd2) ? "R5" : "R7", 64'(id_digest), 64'(m_id));
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(!cmd_acc && !cmd_rej && !map_upd, "R11",
        64'({cmd_acc, cmd_rej, map_upd}), 64'd0);
  endtask

  task automatic reach(int s, int v);
    issue(3'd7, '0, '0);
    if (s >= 1) begin
      issue(3'd1, 16'(v), '0);
      for (int k = 0; k < v; k++) begin
        issue(3'd2, 16'h0A00 + 16'(k * 16'h111), 3'(k + 1));
        issue(3'd3, 16'hC3A5 ^ 16'(k * 16'h0707), '0);
      end
    end
    if (s >= 2) issue(3'd4, '0, '0);
    if (s == 3) issue(3'd5, '0, '0);
  endtask

  initial begin
    logic [DW-1:0] dig_ab;
    repeat (3) @(negedge clk);
    chk(life_state == 2'd0 && !cmd_acc && !cmd_rej && !map_upd && !encl_mode && !id_valid
        && id_digest == '0, "R1", 64'({life_state, cmd_acc, cmd_rej, encl_mode, id_valid}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(life_state == 2'd0 && !id_valid && id_digest == '0, "R1",
        64'(life_state), 64'd0);

    // Sweep every code from every state with several histories
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int v = 0; v < 3; v++) begin
          reach(s, v);
          issue(3'(c), 16'(16'h1357 * (v + 1) + c), 3'(c ^ v));
          idle_check();
          if (m_state == 2'd1) issue(3'd4, '0, '0);
        end
      end
    end

    // Empty build: digest holds only the finalize tag
    issue(3'd7, '0, '0);
    issue(3'd1, '0, '0);
    issue(3'd4, '0, '0);
    chk(id_digest == 32'h4000_0000, "R2", 64'(id_digest), 64'h4000_0000);

    // Order of extends changes the identity
    issue(3'd7, '0, '0);
    issue(3'd1, '0, '0);
    issue(3'd3, 16'h00AA, '0);
    issue(3'd3, 16'h5500, '0);
    issue(3'd4, '0, '0);
    dig_ab = id_digest;
    issue(3'd7, '0, '0);
    issue(3'd1, '0, '0);
    issue(3'd3, 16'h5500, '0);
    issue(3'd3, 16'h00AA, '0);
    issue(3'd4, '0, '0);
    chk(id_digest != dig_ab, "R5", 64'(id_digest), 64'(dig_ab));

    // Frozen after initialize: extend rejected, digest kept
    issue(3'd3, 16'hFFFF, '0);
    issue(3'd5, '0, '0);
    issue(3'd2, 16'h1234, 3'd7);
    issue(3'd6, '0, '0);
    chk(id_digest == m_id, "R6", 64'(id_digest), 64'(m_id));
    idle_check();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule